// File: doc/BRIEF.md
# Serial Receiver with Mute and Wakeup

This block is the receive half of an asynchronous serial port. When enabled it watches the serial line for a falling edge. It confirms the start bit at its middle, then samples each data bit at mid-bit. The bits arrive least significant first. The data field is 7, 8 or 9 bits wide. When parity is on, the top bit of that field is the parity bit. A completed character is handed to the host together with its parity result. Overrun, line-idle and the mute state are reported as well, and the enabled flags are combined into one interrupt.

A baud tick input runs at OVS times the bit rate and paces all sampling. A receiver on a shared multi-drop line can be put into a mute state. While muted it delivers no characters. The receiver leaves mute either when the line has been idle for one whole frame, or when it receives an address character that carries its own node address. The wake method setting selects which of the two applies.

Top module: `uart_rx_mute`

## Requirements
- R1: While rx_en_i is 0 the receiver neither detects start bits nor completes characters. Setting it to 1 starts the hunt for a start bit.
- R2: While en_i is 0, reception in progress is discarded. data_o and every flag (rdy_o, ovr_o, pe_o, idle_o, muted_o) read 0 one cycle later.
- R3: word_len_i selects the data field width: 00 gives 8 bits, 01 gives 9 bits, 10 gives 7 bits, and 11 behaves as 00. The field is received least significant bit first and appears right-aligned in data_o with the unused upper bits at 0. rdy_o is then set.
- R4: A low level on the line is taken as a start bit only if the line still reads low at the middle of that bit. A shorter low pulse is ignored and produces no character.
- R5: With par_en_i at 1, the most significant bit of the field is parity. pe_o is set with the character when the number of ones in the whole field is odd while par_odd_i is 0, or even while par_odd_i is 1.
- R6: If a character completes while rdy_o is 1 and rd_i is not pulsed, ovr_o is set and data_o keeps the earlier character.
- R7: irq_o is 1 when rx_ie_i is 1 and rdy_o or ovr_o is 1. It is also 1 when pe_ie_i is 1 and pe_o is 1, or when idle_ie_i is 1 and idle_o is 1. Otherwise it is 0.
- R8: After enable, or after a start bit is accepted, a run of high line level lasting one frame (field width plus 2 bits) sets idle_o once, provided the receiver is not muted. It does not set again until the next start bit.
- R9: With mute_en_i at 0, muted_o is 0. With mute_en_i at 1, a mute_req_i pulse sets muted_o on the next cycle. rdy_o never rises while the receiver stays muted.
- R10: With wake_addr_i at 0 (idle-line method), a full idle frame while muted clears muted_o and does not set idle_o.
- R11: With wake_addr_i at 1 (address-mark method), a character whose field MSB is 1 is an address. If its low AW bits equal node_addr_i, muted_o clears and the character is delivered. Otherwise muted_o is set and the character is dropped. Data characters received while muted and idle periods leave the receiver muted.
- R12: A one-cycle rd_i pulse clears rdy_o, ovr_o, pe_o and idle_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at OVS times the bit rate |
| rx_i | input | 1 | Serial input line, idles high |
| en_i | input | 1 | Global enable; 0 clears all state |
| rx_en_i | input | 1 | Receiver enable |
| word_len_i | input | 2 | Field width select |
| par_en_i | input | 1 | Parity check enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| mute_en_i | input | 1 | Permits the mute state |
| wake_addr_i | input | 1 | Wake method: 1 address mark, 0 idle line |
| node_addr_i | input | AW | Own node address |
| mute_req_i | input | 1 | Pulse that enters mute |
| rd_i | input | 1 | Read strobe that clears flags |
| rx_ie_i | input | 1 | Interrupt enable for data ready and overrun |
| pe_ie_i | input | 1 | Interrupt enable for parity error |
| idle_ie_i | input | 1 | Interrupt enable for idle |
| data_o | output | 9 | Received field, right-aligned |
| rdy_o | output | 1 | Character waiting |
| pe_o | output | 1 | Parity error on the waiting character |
| ovr_o | output | 1 | Overrun |
| idle_o | output | 1 | Idle line seen |
| muted_o | output | 1 | Receiver is muted |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that mute_req_i is never pulsed in the same cycle that a character completes. They also assume that word_len_i, par_en_i and par_odd_i change only between frames, and that a one-cycle rd_i pulse is the only way the host consumes data. The stimulus meets these assumptions by changing settings only after a frame has ended and the line has been high for more than one bit. It issues mute requests only after the line has been idle for longer than a frame, and it drives every strobe for one cycle on the falling clock edge. Parity is never enabled while address-mark wakeup is in use, because both would claim the field MSB.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DW = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;

  function automatic logic [3:0] data_bits(input logic [1:0] wl);
    case (wl)
      2'b01:   return 4'd9;
      2'b10:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [1:0]    word_len_i,
  output logic          done_o,
  output logic [DW-1:0] field_o,
  output logic          msb_o,
  output logic          xor_o,
  output logic          idle_evt_o
);
  localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2((DW + 2) * OVS + 1);

  logic [1:0]    sync_q;
  logic          line;
  rx_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q, nb_q;
  logic [DW-1:0] sh_q;
  logic [IW-1:0] idle_cnt_q, idle_lim;
  logic          armed_q, done_q, idle_q;

  assign line     = sync_q[1];
  assign idle_lim = IW'((int'(data_bits(word_len_i)) + 2) * OVS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      nb_q       <= 4'd8;
      sh_q       <= '0;
      idle_cnt_q <= '0;
      armed_q    <= 1'b1;
      done_q     <= 1'b0;
      idle_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      idle_q <= 1'b0;
      if (clr_i || !run_i) begin
        st_q       <= ST_IDLE;
        cnt_q      <= '0;
        idx_q      <= '0;
        idle_cnt_q <= '0;
        if (clr_i) armed_q <= 1'b1;
      end else if (tick_i) begin
        case (st_q)
          ST_IDLE: begin
            if (!line) begin
              st_q       <= ST_START;
              cnt_q      <= '0;
              idle_cnt_q <= '0;
              nb_q       <= data_bits(word_len_i);
            end else if (armed_q) begin
              if (idle_cnt_q >= idle_lim - 1'b1) begin
                idle_q     <= 1'b1;
                armed_q    <= 1'b0;
                idle_cnt_q <= '0;
              end else begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
              end
            end
          end
          ST_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              if (line) begin
                st_q <= ST_IDLE;  // noise: start not held to mid-bit
              end else begin
                st_q    <= ST_DATA;
                idx_q   <= '0;
                armed_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q <= '0;
              sh_q  <= {line, sh_q[DW-1:1]};
              if (idx_q == nb_q - 1'b1) st_q <= ST_STOP;
              else                      idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q  <= '0;
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    field_o = sh_q >> (4'(DW) - nb_q);
    msb_o   = field_o[nb_q - 1'b1];
    xor_o   = ^field_o;
  end

  assign done_o     = done_q;
  assign idle_evt_o = idle_q;
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic mute_en_i,
  input  logic wake_addr_i,
  input  logic mute_req_i,
  input  logic done_i,
  input  logic is_addr_i,
  input  logic addr_match_i,
  input  logic idle_evt_i,
  output logic muted_o,
  output logic accept_o
);
  logic muted_q;

  always_comb begin
    if (!done_i)                                       accept_o = 1'b0;
    else if (mute_en_i && wake_addr_i && is_addr_i)    accept_o = addr_match_i;
    else                                               accept_o = !muted_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             muted_q <= 1'b0;
    else if (clr_i || !mute_en_i)            muted_q <= 1'b0;
    else if (mute_req_i)                     muted_q <= 1'b1;
    else if (!wake_addr_i && idle_evt_i)     muted_q <= 1'b0;
    else if (wake_addr_i && done_i && is_addr_i) muted_q <= !addr_match_i;
  end

  assign muted_o = muted_q;
endmodule

// File: rtl/uart_rx_mute.sv
module uart_rx_mute
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int AW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          rx_i,
  input  logic          en_i,
  input  logic          rx_en_i,
  input  logic [1:0]    word_len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          mute_en_i,
  input  logic          wake_addr_i,
  input  logic [AW-1:0] node_addr_i,
  input  logic          mute_req_i,
  input  logic          rd_i,
  input  logic          rx_ie_i,
  input  logic          pe_ie_i,
  input  logic          idle_ie_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          pe_o,
  output logic          ovr_o,
  output logic          idle_o,
  output logic          muted_o,
  output logic          irq_o
);
  logic          clr, done, msb, fxor, idle_evt, accept, muted;
  logic [DW-1:0] field;
  logic [DW-1:0] data_q;
  logic          rdy_q, pe_q, ovr_q, idle_q;

  assign clr = !en_i;

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .run_i      (rx_en_i),
    .tick_i     (baud_tick_i),
    .rx_i       (rx_i),
    .word_len_i (word_len_i),
    .done_o     (done),
    .field_o    (field),
    .msb_o      (msb),
    .xor_o      (fxor),
    .idle_evt_o (idle_evt)
  );

  uart_rx_wake u_wake (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .mute_en_i    (mute_en_i),
    .wake_addr_i  (wake_addr_i),
    .mute_req_i   (mute_req_i),
    .done_i       (done),
    .is_addr_i    (msb),
    .addr_match_i (field[AW-1:0] == node_addr_i),
    .idle_evt_i   (idle_evt),
    .muted_o      (muted),
    .accept_o     (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      idle_q <= 1'b0;
    end else if (clr) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      if (rd_i) begin
        rdy_q  <= 1'b0;
        pe_q   <= 1'b0;
        ovr_q  <= 1'b0;
        idle_q <= 1'b0;
      end
      if (accept) begin
        if (rdy_q && !rd_i) begin
          ovr_q <= 1'b1;  // old character kept
        end else begin
          data_q <= field;
          rdy_q  <= 1'b1;
          pe_q   <= par_en_i && (fxor != par_odd_i);
        end
      end
      if (idle_evt && !muted) idle_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign rdy_o   = rdy_q;
  assign pe_o    = pe_q;
  assign ovr_o   = ovr_q;
  assign idle_o  = idle_q;
  assign muted_o = muted;
  assign irq_o   = (rx_ie_i && (rdy_q || ovr_q)) || (pe_ie_i && pe_q) || (idle_ie_i && idle_q);
endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       mute_en_i,
  input logic       rd_i,
  input logic [8:0] data_o,
  input logic       rdy_o,
  input logic       pe_o,
  input logic       ovr_o,
  input logic       idle_o,
  input logic       muted_o
);
  // R2
  en_off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(rdy_o || ovr_o || pe_o || idle_o || muted_o));

  // R6
  ovr_with_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> rdy_o);

  // R6
  unread_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !rd_i && en_i) |=> $stable(data_o));

  // R9
  mute_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_en_i |=> !muted_o);

  // R9
  no_rdy_in_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (muted_o && $past(muted_o)) |-> !$rose(rdy_o));

  // R10
  no_idle_from_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !$past(muted_o));
endmodule

bind uart_rx_mute uart_rx_mute_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .mute_en_i (mute_en_i),
  .rd_i      (rd_i),
  .data_o    (data_o),
  .rdy_o     (rdy_o),
  .pe_o      (pe_o),
  .ovr_o     (ovr_o),
  .idle_o    (idle_o),
  .muted_o   (muted_o)
);

// File: tb/sim_uart_rx_mute.sv
module sim_uart_rx_mute;
  localparam int OVS = 16;
  localparam int AW  = 4;
  localparam int TDIV = 4;
  localparam int BITC = OVS * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, tick;
  logic [1:0] tdiv = 2'd0;
  logic rx = 1'b1, en = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic mute_en = 1'b0, wake_addr = 1'b0, mute_req = 1'b0;
  logic rd_main = 1'b0, rd_mon = 1'b0, rd;
  logic rx_ie = 1'b0, pe_ie = 1'b0, idle_ie = 1'b0;
  logic [1:0] wl = 2'b00;
  logic [AW-1:0] node = '0;
  logic [8:0] data;
  logic rdy, pe, ovr, idle, muted, irq;

  always #10 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  assign rd   = rd_main | rd_mon;

  uart_rx_mute #(.OVS(OVS), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .rx_i(rx), .en_i(en),
    .rx_en_i(rx_en), .word_len_i(wl), .par_en_i(par_en), .par_odd_i(par_odd),
    .mute_en_i(mute_en), .wake_addr_i(wake_addr), .node_addr_i(node),
    .mute_req_i(mute_req), .rd_i(rd), .rx_ie_i(rx_ie), .pe_ie_i(pe_ie),
    .idle_ie_i(idle_ie), .data_o(data), .rdy_o(rdy), .pe_o(pe), .ovr_o(ovr),
    .idle_o(idle), .muted_o(muted), .irq_o(irq)
  );

  typedef struct { logic [8:0] d; logic p; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_err = 0;
  bit auto_rd = 1'b0, fin = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [8:0] d, input logic p);
    item_t it;
    it.d = d; it.p = p;
    exp_q.push_back(it);
  endtask

  task automatic send(input logic [8:0] bits, input int nb);
    rx = 1'b0; step(BITC);
    for (int i = 0; i < nb; i++) begin rx = bits[i]; step(BITC); end
    rx = 1'b1; step(2 * BITC);
  endtask

  task automatic read_pulse();
    rd_main = 1'b1; step(1); rd_main = 1'b0; step(1);
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected characters as the design raises rdy
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R9 unexpected character", {7'd0, data}, 16'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(data == it.d && pe == it.p, "R3 R5 scoreboard", {6'd0, pe, data}, {6'd0, it.p, it.d});
        end
        rd_mon = 1'b1; @(negedge clk); rd_mon = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    step(3);
    chk({data, rdy, pe, ovr, idle, muted, irq} == '0, "R2 reset state", {1'b0, data, rdy, pe, ovr, idle, muted, irq}, 16'h0);
    rst_n = 1'b1;
    en = 1'b1; rx_en = 1'b1; rx_ie = 1'b1;
    // R8 idle after enable
    step(720);
    chk(idle == 1'b1, "R8 idle after enable", {15'd0, idle}, 16'h1);
    chk(irq == 1'b0, "R7 idle masked", {15'd0, irq}, 16'h0);
    idle_ie = 1'b1; step(1);
    chk(irq == 1'b1, "R7 idle enabled", {15'd0, irq}, 16'h1);
    idle_ie = 1'b0;
    read_pulse();
    chk(idle == 1'b0, "R12 rd clears idle", {15'd0, idle}, 16'h0);
    step(720);
    chk(idle == 1'b0, "R8 idle once per high run", {15'd0, idle}, 16'h0);

    // R3 word lengths
    auto_rd = 1'b1;
    push(9'h0A5, 1'b0); send(9'h0A5, 8);
    push(9'h03C, 1'b0); send(9'h03C, 8);
    wl = 2'b10; push(9'h055, 1'b0); send(9'h0D5, 7);
    wl = 2'b01; push(9'h1A3, 1'b0); send(9'h1A3, 9);
    wl = 2'b00;
    step(20);
    chk(exp_q.size() == 0, "R3 all characters delivered", 16'(exp_q.size()), 16'h0);

    // R5 parity
    par_en = 1'b1; par_odd = 1'b0;
    push(9'h003, 1'b0); send(9'h003, 8);
    push(9'h083, 1'b1); send(9'h083, 8);
    par_odd = 1'b1;
    push(9'h083, 1'b0); send(9'h083, 8);
    par_odd = 1'b0;
    auto_rd = 1'b0; rx_ie = 1'b0; pe_ie = 1'b1;
    send(9'h083, 8);
    chk(pe == 1'b1 && irq == 1'b1, "R5 R7 parity error interrupt", {14'd0, pe, irq}, 16'h3);
    pe_ie = 1'b0; step(1);
    chk(irq == 1'b0, "R7 all masked", {15'd0, irq}, 16'h0);
    read_pulse();
    par_en = 1'b0; rx_ie = 1'b1;

    // R6 overrun
    send(9'h011, 8);
    send(9'h022, 8);
    chk(rdy && ovr, "R6 overrun flags", {14'd0, rdy, ovr}, 16'h3);
    chk(data == 9'h011, "R6 old data kept", {7'd0, data}, 16'h011);
    chk(irq == 1'b1, "R7 irq on data ready and overrun", {15'd0, irq}, 16'h1);
    read_pulse();
    chk(!rdy && !ovr && !pe, "R12 rd clears flags", {13'd0, rdy, ovr, pe}, 16'h0);
    auto_rd = 1'b1;

    // R4 noise start
    rx = 1'b0; step(3 * TDIV); rx = 1'b1;
    step(12 * BITC);
    chk(rdy == 1'b0 && exp_q.size() == 0, "R4 short pulse rejected", {15'd0, rdy}, 16'h0);

    // R1 receiver disabled
    rx_en = 1'b0;
    send(9'h077, 8);
    chk(rdy == 1'b0, "R1 no reception when disabled", {15'd0, rdy}, 16'h0);
    rx_en = 1'b1;
    push(9'h0C3, 1'b0); send(9'h0C3, 8);

    // R10 idle-line wakeup
    step(800); read_pulse();
    mute_en = 1'b1; wake_addr = 1'b0;
    mute_req = 1'b1; step(1); mute_req = 1'b0;
    chk(muted == 1'b1, "R9 mute request immediate", {15'd0, muted}, 16'h1);
    send(9'h044, 8);
    chk(muted == 1'b1 && rdy == 1'b0, "R9 muted drops data", {14'd0, muted, rdy}, 16'h2);
    step(700);
    chk(muted == 1'b0, "R10 idle frame wakes", {15'd0, muted}, 16'h0);
    chk(idle == 1'b0, "R10 waking idle sets no flag", {15'd0, idle}, 16'h0);
    push(9'h066, 1'b0); send(9'h066, 8);

    // R11 address-mark wakeup
    step(800);
    wake_addr = 1'b1; node = 4'h5;
    mute_req = 1'b1; step(1); mute_req = 1'b0;
    send(9'h012, 8);
    chk(muted == 1'b1, "R11 data while muted", {15'd0, muted}, 16'h1);
    send(9'h083, 8);
    chk(muted == 1'b1, "R11 other address stays muted", {15'd0, muted}, 16'h1);
    push(9'h085, 1'b0); send(9'h085, 8);
    chk(muted == 1'b0, "R11 own address wakes", {15'd0, muted}, 16'h0);
    push(9'h020, 1'b0); send(9'h020, 8);
    send(9'h087, 8);
    chk(muted == 1'b1, "R11 other address mutes", {15'd0, muted}, 16'h1);
    step(800);
    chk(muted == 1'b1, "R11 idle does not wake", {15'd0, muted}, 16'h1);
    mute_en = 1'b0; step(1);
    chk(muted == 1'b0, "R9 mute disabled", {15'd0, muted}, 16'h0);
    wake_addr = 1'b0;

    // R2 global disable
    auto_rd = 1'b0;
    send(9'h05A, 8);
    chk(rdy == 1'b1, "R2 setup character held", {15'd0, rdy}, 16'h1);
    en = 1'b0; step(2);
    chk({data, rdy, pe, ovr, idle, muted} == '0, "R2 disable clears", {1'b0, data, rdy, pe, ovr, idle, muted, 1'b0}, 16'h0);
    en = 1'b1; step(2);
    chk(exp_q.size() == 0, "R3 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule